// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the last stage on the read path of a synchronous SRAM. The cycle decoder sorts each cycle as a read beat, a write, a deselect or an idle (burst suspend) cycle. It presents that sorting together with the word the array delivers in the same cycle. From these the block produces the data bus value and one output-drive enable per byte lane. Two static mode inputs shape the timing. `pipe_mode` places a rising-edge output register in the data path, or bypasses it for flow-through operation. `single_desel` chooses whether a deselect turns the drivers off in the cycle the decoder reports it, or one cycle later.

Inside, there is one bit of "presenting read data" state and one delayed copy of it. The combination of the two mode inputs picks which of these gates the drivers. The output enable `oe_n` is active low and purely combinational. Raising it releases every lane at once. Lowering it can only re-enable lanes that the state says should be driving.

Top module: `sram_rd_out`

## Requirements
- R1: With `pipe_mode`=0, a read beat's `arr_data` appears on `dq_out` in the same cycle the decoder flags it, and the lanes drive in that cycle (2-1-1-1 latency counted from the command edge).
- R2: With `pipe_mode`=1, a read beat's data is captured at the next rising edge and driven during the following cycle from the register; the lanes begin driving one cycle after the first beat of a read (3-1-1-1).
- R3: With `single_desel`=1, the lanes are released in the same cycle the deselect is flagged. In pipelined mode, the registered word of the last read is therefore never driven.
- R4: With `single_desel`=0, a deselect is held for one full cycle. During the deselect cycle the lanes still drive the most recent read word, and they are released from the next cycle on.
- R5: In a cycle flagged as a write, every lane is released whatever the byte enables. A write also ends the read state, like a deselect with single-cycle timing.
- R6: `oe_n`=1 releases every lane combinationally, at any point in a cycle. `oe_n`=0 enables lanes only when the read state calls for driving.
- R7: All byte lanes of `dq_oe` always carry the same value; reads drive every lane.
- R8: After reset, `dq_out` is zero and every lane is released.
- R9: An idle cycle (no flag raised) keeps the previous drive state and the previously presented read word (burst suspend).
- R10: When several flags are raised in one cycle, write wins over deselect and deselect wins over read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_data | input | LANES*LANE_W | Word from the array in the current cycle |
| rd_vld | input | 1 | Current cycle is a read beat |
| wr_cyc | input | 1 | Current cycle is a write |
| dsel | input | 1 | Current cycle is a deselect |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 = output register used, 0 = flow-through |
| single_desel | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle |
| dq_out | output | LANES*LANE_W | Data bus value |
| dq_oe | output | LANES | Per-lane drive enable, 1 = driving |

## Verification
The bench builds the block with 3 lanes of 5 bits. The odd lane count and lane width bring the lane broadcast and the lane slicing of the data path within reach, in a bus that is still small. For each of the four mode combinations it runs 400 pseudo-random cycles. These include overlapping flags, idle runs and `oe_n` pulses, so every sequence of read, write, deselect and suspend reaches each timing tap. A model built on the cycle history predicts the expected drive state and word. In addition, `oe_n` is toggled in the middle of a cycle to show that the enable path has no register.

// File: rtl/sram_rd_out.sv
module sram_rd_out #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] arr_data,
  input  logic          rd_vld,
  input  logic          wr_cyc,
  input  logic          dsel,
  input  logic          oe_n,
  input  logic          pipe_mode,
  input  logic          single_desel,
  output logic [DW-1:0] dq_out,
  output logic [LANES-1:0] dq_oe
);

  // cycle class after priority: write > deselect > read
  logic rd_eff, stop_eff;
  assign stop_eff = wr_cyc | dsel;
  assign rd_eff   = rd_vld & ~stop_eff;

  // read-presenting state: now and one edge ago
  logic st_d, st_now;
  assign st_now = rd_eff | (~stop_eff & st_d);

  logic [DW-1:0] q_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_d  <= 1'b0;
      q_reg <= '0;
    end else begin
      st_d <= st_now;
      if (rd_eff) q_reg <= arr_data;
    end
  end

  // tap chosen by the two modes
  logic en_state;
  always_comb begin
    unique case ({pipe_mode, single_desel})
      2'b01:   en_state = st_now;
      2'b00:   en_state = st_now | st_d;
      2'b11:   en_state = st_now & st_d;
      default: en_state = st_d;
    endcase
  end

  logic drive;
  assign drive = en_state & ~wr_cyc & ~oe_n;

  logic bypass;
  assign bypass = ~pipe_mode & rd_eff;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dq_oe[i] = drive;
    assign dq_out[i*LANE_W +: LANE_W] =
      bypass ? arr_data[i*LANE_W +: LANE_W] : q_reg[i*LANE_W +: LANE_W];
  end

  AST_FT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_vld && !wr_cyc && !dsel) |-> dq_out == arr_data); // R1

  AST_PIPE_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(rd_vld && !wr_cyc && !dsel)) |-> dq_out == $past(arr_data)); // R2

  AST_SCD_IMMEDIATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (single_desel && dsel) |-> dq_oe == '0); // R3

  AST_DCD_PIPE_LATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !single_desel && $past(pipe_mode && !single_desel && dsel && !rd_vld))
      |-> dq_oe == '0); // R4

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |-> dq_oe == '0); // R5

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dq_oe == '0); // R6

  AST_LANES_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dq_oe) == 0) || ($countones(dq_oe) == LANES)); // R7

endmodule

// File: tb/tb_sram_rd_out.sv
module tb_sram_rd_out;
  localparam int CLK_T  = 10;
  localparam int LANES  = 3;
  localparam int LANE_W = 5;
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] arr_data = '0;
  logic rd_vld = 1'b0, wr_cyc = 1'b0, dsel = 1'b0, oe_n = 1'b0;
  logic pipe_mode = 1'b0, single_desel = 1'b0;
  logic [DW-1:0] dq_out;
  logic [LANES-1:0] dq_oe;

  sram_rd_out #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .arr_data(arr_data), .rd_vld(rd_vld),
    .wr_cyc(wr_cyc), .dsel(dsel), .oe_n(oe_n), .pipe_mode(pipe_mode),
    .single_desel(single_desel), .dq_out(dq_out), .dq_oe(dq_oe));

  always #(CLK_T/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [31:0] rs = 32'h1badf00d;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] x = v;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    for (int mode = 0; mode < 4; mode++) begin
      logic s_prev, s_n, exp_on;
      logic [DW-1:0] last, exp_d;
      logic [LANES-1:0] all_on;
      all_on = '1;
      pipe_mode = mode[1]; single_desel = mode[0];
      rst_n = 0; rd_vld = 0; wr_cyc = 0; dsel = 0; oe_n = 0; arr_data = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      chk("R8 reset oe", DW'(dq_oe), '0);
      chk("R8 reset data", dq_out, '0);
      s_prev = 0; last = '0;
      for (int n = 0; n < 400; n++) begin
        int cls; // 0 read 1 write 2 desel 3 idle
        string tag;
        logic [2:0] code;
        @(posedge clk); #1;
        rs = nxt(rs);
        code = rs[2:0];
        rd_vld = (code <= 3'd2) || code == 3'd6 || code == 3'd7;
        wr_cyc = (code == 3'd3) || code == 3'd7;
        dsel   = (code == 3'd4) || code == 3'd6 || code == 3'd7;
        if (rs[11:9] == 3'd0) begin rd_vld = 0; wr_cyc = 0; dsel = 0; end
        oe_n = (rs[5:3] == 3'd0);
        arr_data = rs[30:16];
        cls = wr_cyc ? 1 : dsel ? 2 : rd_vld ? 0 : 3;
        s_n = (cls == 0) ? 1'b1 : (cls == 3) ? s_prev : 1'b0;
        case ({pipe_mode, single_desel})
          2'b01: exp_on = s_n;
          2'b00: exp_on = s_n | s_prev;
          2'b11: exp_on = s_n & s_prev;
          default: exp_on = s_prev;
        endcase
        if (cls == 1 || oe_n) exp_on = 0;
        exp_d = (!pipe_mode && cls == 0) ? arr_data : last;
        if (cls == 1) tag = "R5";
        else if (oe_n) tag = "R6";
        else if (code >= 3'd6 && rs[11:9] != 3'd0) tag = "R10";
        else if (cls == 3) tag = "R9";
        else if (cls == 2) tag = single_desel ? "R3" : "R4";
        else tag = pipe_mode ? "R2" : "R1";
        #(CLK_T/2 - 1);
        chk({tag, " R7 oe"}, DW'(dq_oe), exp_on ? DW'(all_on) : '0);
        if (exp_on) begin
          chk({tag, " data"}, dq_out, exp_d);
          #1 oe_n = 1; #1;
          chk("R6 async release", DW'(dq_oe), '0);
          oe_n = 0; #1;
          chk("R6 async restore", DW'(dq_oe), DW'(all_on));
        end
        s_prev = s_n;
        if (cls == 0) last = arr_data;
      end
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule